// File: doc/BRIEF.md
# Joinable Transmit/Receive FIFO Pair

This block holds two word-wide queues between a host and a processing machine. The transmit queue carries words from the host to the machine, and the receive queue carries words from the machine back to the host. Each queue has its own storage bank of `DEPTH` entries. A 6-bit status word gives the host the empty and full state of both queues and two sticky error flags.

Two join inputs let one queue take over the other's bank. That queue then holds twice as many words, and the queue that gave up its bank reads as full and empty at once. A change on either join input empties both queues, so pulsing a join bit high and then low is the way to clear them. Words leave each queue in the order they were written. The host's write and read strobes and the machine's pull and push strobes each move at most one word per clock. The head word of each queue is always visible on that queue's read-data output.

Top module: `fifo_pair_join`

## Requirements
- R1: With both join inputs low, each queue accepts exactly `DEPTH` (4) words. Further writes change nothing.
- R2: Status bit 0 (transmit empty) and bit 2 (receive empty) are 1 exactly when the queue holds no word, or when that queue is disabled.
- R3: Status bit 1 (transmit full) and bit 3 (receive full) are 1 exactly when the queue holds its capacity, or when that queue is disabled.
- R4: With `join_rx_i` high and `join_tx_i` low, the receive queue holds 8 words. The transmit queue is disabled: its status bits 0 and 1 are both 1 and it accepts no word.
- R5: With `join_tx_i` high and `join_rx_i` low, the transmit queue holds 8 words and the receive queue is disabled. With both join inputs high, both queues are disabled.
- R6: The clock edge at which either join input differs from its value at the previous edge empties both queues. Any word transfer requested in that cycle is dropped.
- R7: A machine pull from an empty transmit queue, or a machine push into a full receive queue, is ignored. It does not stall, moves no data and sets no error flag.
- R8: A host write while the transmit queue is full is ignored and sets sticky status bit 4. A host read while the receive queue is empty is ignored and sets sticky status bit 5. `err_clr_i[0]` clears bit 4 and `err_clr_i[1]` clears bit 5. A new error in the same cycle as a clear wins.
- R9: A push and a pop in the same cycle on a queue that is neither empty nor full leave its fill level unchanged.
- R10: Words leave each queue in the order they were accepted, in every join mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host writes one word into the transmit queue |
| host_wdata_i | input | DW | Word written by the host |
| host_rd_i | input | 1 | Host removes the head word of the receive queue |
| host_rdata_o | output | DW | Head word of the receive queue |
| mach_pull_i | input | 1 | Machine removes the head word of the transmit queue |
| mach_pull_data_o | output | DW | Head word of the transmit queue |
| mach_push_i | input | 1 | Machine writes one word into the receive queue |
| mach_push_data_i | input | DW | Word written by the machine |
| join_tx_i | input | 1 | Give the receive bank to the transmit queue |
| join_rx_i | input | 1 | Give the transmit bank to the receive queue |
| err_clr_i | input | 2 | Write-1 clear of status bit 4 (bit 0) and bit 5 (bit 1) |
| status_o | output | 6 | {rd_err, wr_err, rx_full, rx_empty, tx_full, tx_empty} |

## Verification
Every transfer, error flag and flush takes effect at the clock edge that samples the request. Status and head-word outputs are driven from registers with no further pipeline, so each result is due one edge after its stimulus. The bench changes inputs on the falling edge and samples on the next falling edge, which puts exactly one rising edge between a stimulus and its check. A head word is compared before the pop that removes it. After a join change, the bench checks once the single flushing edge has passed.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int unsigned ST_TX_EMPTY = 0;
  localparam int unsigned ST_TX_FULL  = 1;
  localparam int unsigned ST_RX_EMPTY = 2;
  localparam int unsigned ST_RX_FULL  = 3;
  localparam int unsigned ST_WR_ERR   = 4;
  localparam int unsigned ST_RD_ERR   = 5;
  localparam int unsigned ST_W        = 6;

  typedef struct packed {
    logic tx;
    logic rx;
  } join_t;
endpackage

// File: rtl/jfifo_store.sv
module jfifo_store #(
  parameter int unsigned DW = 32,
  parameter int unsigned N  = 8,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_waddr_i,
  input  logic [DW-1:0] a_wdata_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_waddr_i,
  input  logic [DW-1:0] b_wdata_i,
  input  logic [AW-1:0] a_raddr_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic [AW-1:0] b_raddr_i,
  output logic [DW-1:0] b_rdata_o
);
  logic [DW-1:0] ent [N];

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic [DW-1:0] q;
    // the two ports never address the same entry in any join mode
    always_ff @(posedge clk_i) begin
      if (a_we_i && a_waddr_i == AW'(e)) q <= a_wdata_i;
      else if (b_we_i && b_waddr_i == AW'(e)) q <= b_wdata_i;
    end
    assign ent[e] = q;
  end

  assign a_rdata_o = ent[a_raddr_i];
  assign b_rdata_o = ent[b_raddr_i];
endmodule

// File: rtl/jfifo_ctrl.sv
module jfifo_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SPAN = 2 * DEPTH,
  localparam int unsigned AW   = $clog2(SPAN),
  localparam int unsigned CW   = $clog2(SPAN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          en_i,
  input  logic          wide_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_ok_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o
);
  logic [CW-1:0] cnt_q, cap;
  logic [AW-1:0] wptr_q, rptr_q, last;
  logic          pop_ok;

  assign cap     = wide_i ? CW'(SPAN) : CW'(DEPTH);
  assign last    = AW'(cap - CW'(1));
  assign full_o  = !en_i || (cnt_q == cap);
  assign empty_o = !en_i || (cnt_q == '0);

  assign push_ok_o = push_i && !full_o && !flush_i;
  assign pop_ok    = pop_i && !empty_o && !flush_i;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [AW-1:0] lim);
    return (p == lim) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush_i) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_ok_o) wptr_q <= bump(wptr_q, last);
      if (pop_ok)    rptr_q <= bump(rptr_q, last);
      cnt_q <= cnt_q + CW'(push_ok_o) - CW'(pop_ok);
    end
  end

  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;
endmodule

// File: rtl/fifo_pair_join.sv
module fifo_pair_join
  import fifo_pair_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            host_wr_i,
  input  logic [DW-1:0]   host_wdata_i,
  input  logic            host_rd_i,
  output logic [DW-1:0]   host_rdata_o,
  input  logic            mach_pull_i,
  output logic [DW-1:0]   mach_pull_data_o,
  input  logic            mach_push_i,
  input  logic [DW-1:0]   mach_push_data_i,
  input  logic            join_tx_i,
  input  logic            join_rx_i,
  input  logic [1:0]      err_clr_i,
  output logic [ST_W-1:0] status_o
);
  localparam int unsigned SPAN = 2 * DEPTH;
  localparam int unsigned AW   = $clog2(SPAN);

  join_t join_q, join_now;
  logic  flush;
  logic  tx_full, tx_empty, rx_full, rx_empty;
  logic  tx_push_ok, rx_push_ok;
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp, rx_base;
  logic  wr_err_q, rd_err_q;

  assign join_now = '{tx: join_tx_i, rx: join_rx_i};
  assign flush    = (join_now != join_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) join_q <= '0;
    else         join_q <= join_now;
  end

  jfifo_ctrl #(.DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni,
    .flush_i   (flush),
    .en_i      (!join_q.rx),
    .wide_i    (join_q.tx),
    .push_i    (host_wr_i),
    .pop_i     (mach_pull_i),
    .full_o    (tx_full),
    .empty_o   (tx_empty),
    .push_ok_o (tx_push_ok),
    .wptr_o    (tx_wp),
    .rptr_o    (tx_rp)
  );

  jfifo_ctrl #(.DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni,
    .flush_i   (flush),
    .en_i      (!join_q.tx),
    .wide_i    (join_q.rx),
    .push_i    (mach_push_i),
    .pop_i     (host_rd_i),
    .full_o    (rx_full),
    .empty_o   (rx_empty),
    .push_ok_o (rx_push_ok),
    .wptr_o    (rx_wp),
    .rptr_o    (rx_rp)
  );

  // transmit owns the low bank, receive the high bank unless it spans both
  assign rx_base = join_q.rx ? '0 : AW'(DEPTH);

  jfifo_store #(.DW(DW), .N(SPAN)) u_store (
    .clk_i,
    .a_we_i    (tx_push_ok),
    .a_waddr_i (tx_wp),
    .a_wdata_i (host_wdata_i),
    .b_we_i    (rx_push_ok),
    .b_waddr_i (rx_wp + rx_base),
    .b_wdata_i (mach_push_data_i),
    .a_raddr_i (tx_rp),
    .a_rdata_o (mach_pull_data_o),
    .b_raddr_i (rx_rp + rx_base),
    .b_rdata_o (host_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_err_q <= 1'b0;
      rd_err_q <= 1'b0;
    end else begin
      if (host_wr_i && tx_full) wr_err_q <= 1'b1;
      else if (err_clr_i[0])    wr_err_q <= 1'b0;
      if (host_rd_i && rx_empty) rd_err_q <= 1'b1;
      else if (err_clr_i[1])     rd_err_q <= 1'b0;
    end
  end

  always_comb begin
    status_o              = '0;
    status_o[ST_TX_EMPTY] = tx_empty;
    status_o[ST_TX_FULL]  = tx_full;
    status_o[ST_RX_EMPTY] = rx_empty;
    status_o[ST_RX_FULL]  = rx_full;
    status_o[ST_WR_ERR]   = wr_err_q;
    status_o[ST_RD_ERR]   = rd_err_q;
  end
endmodule

// File: rtl/fifo_pair_join_chk.sv
module fifo_pair_join_chk
  import fifo_pair_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            host_wr_i,
  input logic            host_rd_i,
  input logic            mach_pull_i,
  input logic            join_tx_i,
  input logic            join_rx_i,
  input logic            jq_tx,
  input logic            jq_rx,
  input logic [1:0]      err_clr_i,
  input logic [ST_W-1:0] status_o
);
  logic chg;
  assign chg = (join_tx_i != jq_tx) || (join_rx_i != jq_rx);

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> status_o[ST_TX_EMPTY] && status_o[ST_RX_EMPTY]); // R6

  AST_TX_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jq_rx |-> status_o[ST_TX_EMPTY] && status_o[ST_TX_FULL]); // R4

  AST_RX_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jq_tx |-> status_o[ST_RX_EMPTY] && status_o[ST_RX_FULL]); // R5

  AST_ENABLED_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jq_tx && !jq_rx) |-> !(status_o[ST_TX_EMPTY] && status_o[ST_TX_FULL])); // R2

  AST_WR_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && status_o[ST_TX_FULL]) |=> status_o[ST_WR_ERR]); // R8

  AST_RD_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_RD_ERR] && !err_clr_i[1]) |=> status_o[ST_RD_ERR]); // R8

  AST_PUSH_POP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && mach_pull_i && !chg && !status_o[ST_TX_FULL] && !status_o[ST_TX_EMPTY])
      |=> $stable(status_o[ST_TX_FULL:ST_TX_EMPTY])); // R9
endmodule

bind fifo_pair_join fifo_pair_join_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_wr_i   (host_wr_i),
  .host_rd_i   (host_rd_i),
  .mach_pull_i (mach_pull_i),
  .join_tx_i   (join_tx_i),
  .join_rx_i   (join_rx_i),
  .jq_tx       (join_q.tx),
  .jq_rx       (join_q.rx),
  .err_clr_i   (err_clr_i),
  .status_o    (status_o)
);

// File: tb/fifo_pair_join_test.sv
module fifo_pair_join_test;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic host_wr = 0, host_rd = 0, mach_pull = 0, mach_push = 0;
  logic join_tx = 0, join_rx = 0;
  logic [1:0] err_clr = 0;
  logic [DW-1:0] host_wdata = 0, mach_push_data = 0;
  logic [DW-1:0] host_rdata, mach_pull_data;
  logic [5:0] status;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  fifo_pair_join #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .host_rd_i(host_rd), .host_rdata_o(host_rdata),
    .mach_pull_i(mach_pull), .mach_pull_data_o(mach_pull_data),
    .mach_push_i(mach_push), .mach_push_data_i(mach_push_data),
    .join_tx_i(join_tx), .join_rx_i(join_rx),
    .err_clr_i(err_clr), .status_o(status)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one rising edge, then back at the falling edge with strobes released
  task automatic step();
    @(negedge clk);
    host_wr = 0; host_rd = 0; mach_pull = 0; mach_push = 0; err_clr = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int m, input int dir, input int i);
    return 32'hA500_0000 + DW'(m * 256 + dir * 64 + i);
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset", DW'(status), DW'(6'b00_0101));
    rst_ni = 1'b1;
    step();

    // sweep all four join modes
    for (int m = 0; m < 4; m++) begin
      int tcap, rcap;
      join_tx = m[0];
      join_rx = m[1];
      tcap = join_rx ? 0 : (join_tx ? 2 * DEPTH : DEPTH);
      rcap = join_tx ? 0 : (join_rx ? 2 * DEPTH : DEPTH);
      step();
      step();
      chk("R6 mode empty tx", DW'(status[0]), 1);
      chk("R6 mode empty rx", DW'(status[2]), 1);
      chk("R4 R5 tx disabled full", DW'(status[1]), DW'(tcap == 0));
      chk("R4 R5 rx disabled full", DW'(status[3]), DW'(rcap == 0));

      // transmit: host overfills, machine drains
      for (int i = 0; i < 10; i++) begin
        host_wr = 1; host_wdata = pat(m, 0, i);
        step();
        if (i + 1 == tcap) chk("R1 R3 tx full at cap", DW'(status[1]), 1);
        if (i + 1 < tcap)  chk("R3 tx not full below cap", DW'(status[1]), 0);
      end
      chk("R8 wr err set", DW'(status[4]), 1);
      err_clr = 2'b01; step();
      chk("R8 wr err clear", DW'(status[4]), 0);
      for (int i = 0; i < tcap; i++) begin
        chk("R10 tx order", mach_pull_data, pat(m, 0, i));
        mach_pull = 1; step();
      end
      chk("R2 tx empty after drain", DW'(status[0]), 1);
      mach_pull = 1; step();
      chk("R7 pull empty no err", DW'(status[5:4]), 0);
      chk("R7 pull empty status", DW'(status[1:0]), DW'(tcap == 0 ? 2'b11 : 2'b01));

      // receive: machine overfills, host drains
      for (int i = 0; i < 10; i++) begin
        mach_push = 1; mach_push_data = pat(m, 1, i);
        step();
        if (i + 1 == rcap) chk("R1 R3 rx full at cap", DW'(status[3]), 1);
        if (i + 1 < rcap)  chk("R3 rx not full below cap", DW'(status[3]), 0);
      end
      chk("R7 push full no err", DW'(status[5:4]), 0);
      for (int i = 0; i < rcap; i++) begin
        chk("R10 rx order", host_rdata, pat(m, 1, i));
        host_rd = 1; step();
      end
      chk("R2 rx empty after drain", DW'(status[2]), 1);
      host_rd = 1; step();
      chk("R8 rd err set", DW'(status[5]), 1);
      step();
      chk("R8 rd err sticky", DW'(status[5]), 1);
      err_clr = 2'b10; step();
      chk("R8 rd err clear", DW'(status[5]), 0);
    end

    // flush by pulsing a join bit
    join_tx = 0; join_rx = 0;
    step(); step();
    for (int i = 0; i < 3; i++) begin
      host_wr = 1; host_wdata = pat(9, 0, i);
      mach_push = 1; mach_push_data = pat(9, 1, i);
      step();
    end
    chk("R6 pre flush tx", DW'(status[0]), 0);
    join_rx = 1; step();
    join_rx = 0; step();
    step();
    chk("R6 flushed tx", DW'(status[1:0]), 2'b01);
    chk("R6 flushed rx", DW'(status[3:2]), 2'b01);
    // after flush the order restarts cleanly
    host_wr = 1; host_wdata = pat(10, 0, 0); step();
    chk("R6 R10 post flush head", mach_pull_data, pat(10, 0, 0));

    // simultaneous push and pop keeps the level
    mach_pull = 1; step();
    host_wr = 1; host_wdata = pat(11, 0, 0); step();
    host_wr = 1; host_wdata = pat(11, 0, 1); step();
    for (int i = 0; i < 6; i++) begin
      int exp_idx;
      exp_idx = i;
      chk("R9 R10 head during overlap", mach_pull_data, pat(11, 0, exp_idx));
      host_wr = 1; host_wdata = pat(11, 0, i + 2);
      mach_pull = 1;
      step();
      chk("R9 level kept", DW'(status[1:0]), 0);
    end
    for (int i = 6; i < 8; i++) begin
      chk("R9 remaining", mach_pull_data, pat(11, 0, i));
      mach_pull = 1; step();
    end
    chk("R9 exactly two left", DW'(status[0]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule